// File: doc/BRIEF.md
# Indirect SDRAM Bank Configuration Front End

This block is the register-facing front of a memory controller. Software reaches it through two locations on a narrow register bus. One location is an index register that names an internal register. The other is a data port that reads or writes the register the index names. Behind that pair sit the configuration, read-only status, refresh, idle, timing, ECC configuration and ECC error status registers, two error status registers, an error address register and one configuration word per memory bank.

The block also compares an incoming physical address with the bank windows in every cycle. A bank window is live only when its own enable flag and the global controller enable are both set. The result is a bank index with a valid flag, the address relative to the bank base, and a miss flag. A level interrupt signals that the ECC error status register holds a nonzero value. Command sequencing, refresh timing and the data path are handled elsewhere.

The data port writes on the rising clock edge. Read data is combinational from the current bus address and index. The decode outputs are combinational from the physical address and the register contents.

Top module: `sdram_cfg_front`

## Requirements
- R1: After reset, a read through the data port returns these values. Configuration (offset 0x20) reads 0x00800000. Idle (0x34) reads 0x07C00000. Refresh (0x30) reads 0x05F00000. Timing (0x80) reads 0x00854009. Every other register reads zero. The ECC interrupt is low and the decode reports a miss.
- R2: A write to bus address 0x10 loads the index register, and a read of that address returns the index. A write to bus address 0x11 stores into the register at the current index. A read of 0x11 returns that register. An index that names no register reads zero, and a write to it changes nothing.
- R3: The bank configuration registers sit at offsets 0x40, 0x44, 0x48 and 0x4C, for banks 0 to 3. A write stores the value ANDed with 0xFFDEE001. Bits 31:23 hold the base, bits 19:17 hold a size code, and bit 0 is the bank enable.
- R4: A bank window spans 4 MiB shifted left by the size code, starting at the base. An address inside the window of a live bank sets the hit-valid output, puts the bank number on the bank index output and outputs the address minus the base as the offset.
- R5: A bank is live only when its enable bit and configuration bit 31 are both set. Any address outside all live windows raises the miss flag, clears the hit-valid output and drives a zero offset.
- R6: When an address falls inside several live windows, the bank with the lowest number is reported.
- R7: A write that takes configuration bit 31 from 0 to 1 clears status bit 31. A write that takes it from 1 to 0 sets status bit 31.
- R8: A write that raises configuration bit 30 sets status bit 30, and a write that lowers it clears status bit 30. Writes to the status register at 0x24 have no effect.
- R9: Writing the error status registers at 0x00 or 0x08 clears the bits that are written as one. The error address register at 0x10 stores the full value written.
- R10: Refresh keeps the bits of 0x3FF80000. Timing keeps 0x018FC01F. ECC configuration (0x94) keeps 0x00F00000. Idle stores the written value ANDed with 0xF8000000, then ORed with 0x07C00000.
- R11: The ECC interrupt is high exactly while the ECC error status register (0x98) is nonzero. That register stores the full value written, and the interrupt follows from the clock edge of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 10 | Register bus address |
| bus_wr | input | 1 | Register bus write strobe |
| bus_wdata | input | 32 | Register bus write data |
| bus_rdata | output | 32 | Register bus read data (combinational) |
| phys_addr | input | 32 | Physical address to decode |
| hit_valid | output | 1 | Address falls in a live bank |
| hit_bank | output | 2 | Number of the winning bank |
| bank_offset | output | 32 | Address relative to the winning bank base |
| miss | output | 1 | Address falls in no live bank |
| ecc_irq | output | 1 | ECC error interrupt, level |

## Verification
A corrupted register in this block shows up at the ports in two ways. The next data-port read of that offset returns the wrong value. For a bank word or the controller enable, the decode outputs also change at once, in the same cycle the register changes. A wrong status bit would stay hidden until the status offset is read. For that reason the bench reads status back after every configuration edge rather than only at the end. A wrong ECC error status shows on the interrupt pin one edge after the write, and the bench samples that pin there.

// File: rtl/sdcfg_pkg.sv
package sdcfg_pkg;

    localparam int WORD_W = 32;

    // Internal register offsets reached through the index register
    localparam logic [31:0] OFS_ERRST0  = 32'h00;
    localparam logic [31:0] OFS_ERRST1  = 32'h08;
    localparam logic [31:0] OFS_ERRADR  = 32'h10;
    localparam logic [31:0] OFS_CONFIG  = 32'h20;
    localparam logic [31:0] OFS_STATUS  = 32'h24;
    localparam logic [31:0] OFS_REFRSH  = 32'h30;
    localparam logic [31:0] OFS_IDLE    = 32'h34;
    localparam logic [31:0] OFS_BANK0   = 32'h40;
    localparam logic [31:0] OFS_TIMING  = 32'h80;
    localparam logic [31:0] OFS_ECCCFG  = 32'h94;
    localparam logic [31:0] OFS_ECCERR  = 32'h98;

    // Write masks
    localparam logic [31:0] MSK_BANK   = 32'hFFDE_E001;
    localparam logic [31:0] MSK_REFRSH = 32'h3FF8_0000;
    localparam logic [31:0] MSK_TIMING = 32'h018F_C01F;
    localparam logic [31:0] MSK_ECCCFG = 32'h00F0_0000;
    localparam logic [31:0] MSK_IDLE   = 32'hF800_0000;
    localparam logic [31:0] FIX_IDLE   = 32'h07C0_0000;

    // Reset values
    localparam logic [31:0] RST_CONFIG = 32'h0080_0000;
    localparam logic [31:0] RST_REFRSH = 32'h05F0_0000;
    localparam logic [31:0] RST_TIMING = 32'h0085_4009;
    localparam logic [31:0] RST_IDLE   = 32'h07C0_0000;

    localparam int CFG_EN_BIT  = 31;
    localparam int CFG_AUX_BIT = 30;

    typedef struct packed {
        logic [8:0]  base_hi;   // 31:23
        logic [2:0]  pad_a;     // 22:20
        logic [2:0]  size_code; // 19:17
        logic [15:0] pad_b;     // 16:1
        logic        enable;    // 0
    } bank_word_t;

    // Window span: 4 MiB shifted left by the code, one bit wider than an address
    function automatic logic [32:0] window_span(input logic [2:0] code);
        return 33'h0040_0000 << code;
    endfunction

endpackage

// File: rtl/sdcfg_regfile.sv
module sdcfg_regfile
    import sdcfg_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BUS_AW    = 10,
    parameter logic [BUS_AW-1:0] IDX_PORT  = 10'h010,
    parameter logic [BUS_AW-1:0] DATA_PORT = 10'h011
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [BUS_AW-1:0]       bus_addr,
    input  logic                    bus_wr,
    input  logic [WORD_W-1:0]       bus_wdata,
    output logic [WORD_W-1:0]       bus_rdata,
    output logic [NUM_BANKS-1:0][WORD_W-1:0] bank_q,
    output logic                    ctrl_en,
    output logic [WORD_W-1:0]       status_q,
    output logic [WORD_W-1:0]       eccerr_q
);
    logic [WORD_W-1:0] index_q;
    logic [WORD_W-1:0] errst0_q, errst1_q, erradr_q, config_q;
    logic [WORD_W-1:0] refrsh_q, idle_q, timing_q, ecccfg_q;
    logic [WORD_W-1:0] data_rd;

    wire idx_wr  = bus_wr && (bus_addr == IDX_PORT);
    wire data_wr = bus_wr && (bus_addr == DATA_PORT);

    function automatic logic at(input logic [31:0] ofs);
        return index_q == ofs;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            index_q  <= '0;
            errst0_q <= '0;
            errst1_q <= '0;
            erradr_q <= '0;
            config_q <= RST_CONFIG;
            status_q <= '0;
            refrsh_q <= RST_REFRSH;
            idle_q   <= RST_IDLE;
            timing_q <= RST_TIMING;
            ecccfg_q <= '0;
            eccerr_q <= '0;
        end else begin
            if (idx_wr) index_q <= bus_wdata;
            if (data_wr) begin
                if (at(OFS_ERRST0)) errst0_q <= errst0_q & ~bus_wdata;
                if (at(OFS_ERRST1)) errst1_q <= errst1_q & ~bus_wdata;
                if (at(OFS_ERRADR)) erradr_q <= bus_wdata;
                if (at(OFS_REFRSH)) refrsh_q <= bus_wdata & MSK_REFRSH;
                if (at(OFS_IDLE))   idle_q   <= (bus_wdata & MSK_IDLE) | FIX_IDLE;
                if (at(OFS_TIMING)) timing_q <= bus_wdata & MSK_TIMING;
                if (at(OFS_ECCCFG)) ecccfg_q <= bus_wdata & MSK_ECCCFG;
                if (at(OFS_ECCERR)) eccerr_q <= bus_wdata;
                if (at(OFS_CONFIG)) begin
                    config_q <= bus_wdata;
                    if (!config_q[CFG_EN_BIT] && bus_wdata[CFG_EN_BIT])
                        status_q[CFG_EN_BIT] <= 1'b0;
                    else if (config_q[CFG_EN_BIT] && !bus_wdata[CFG_EN_BIT])
                        status_q[CFG_EN_BIT] <= 1'b1;
                    if (!config_q[CFG_AUX_BIT] && bus_wdata[CFG_AUX_BIT])
                        status_q[CFG_AUX_BIT] <= 1'b1;
                    else if (config_q[CFG_AUX_BIT] && !bus_wdata[CFG_AUX_BIT])
                        status_q[CFG_AUX_BIT] <= 1'b0;
                end
            end
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [31:0] BANK_OFS = OFS_BANK0 + 32'(4 * b);
        always_ff @(posedge clk) begin
            if (rst)
                bank_q[b] <= '0;
            else if (data_wr && at(BANK_OFS))
                bank_q[b] <= bus_wdata & MSK_BANK;
        end
    end

    always_comb begin
        data_rd = '0;
        if (at(OFS_ERRST0)) data_rd = errst0_q;
        if (at(OFS_ERRST1)) data_rd = errst1_q;
        if (at(OFS_ERRADR)) data_rd = erradr_q;
        if (at(OFS_CONFIG)) data_rd = config_q;
        if (at(OFS_STATUS)) data_rd = status_q;
        if (at(OFS_REFRSH)) data_rd = refrsh_q;
        if (at(OFS_IDLE))   data_rd = idle_q;
        if (at(OFS_TIMING)) data_rd = timing_q;
        if (at(OFS_ECCCFG)) data_rd = ecccfg_q;
        if (at(OFS_ECCERR)) data_rd = eccerr_q;
        for (int b = 0; b < NUM_BANKS; b++)
            if (at(OFS_BANK0 + 32'(4 * b))) data_rd = bank_q[b];
    end

    always_comb begin
        if (bus_addr == IDX_PORT)       bus_rdata = index_q;
        else if (bus_addr == DATA_PORT) bus_rdata = data_rd;
        else                            bus_rdata = '0;
    end

    assign ctrl_en = config_q[CFG_EN_BIT];

endmodule

// File: rtl/sdcfg_bank_decode.sv
module sdcfg_bank_decode
    import sdcfg_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic [NUM_BANKS-1:0][WORD_W-1:0] bank_q,
    input  logic                    ctrl_en,
    input  logic [WORD_W-1:0]       phys_addr,
    output logic                    hit_valid,
    output logic [BANK_W-1:0]       hit_bank,
    output logic [WORD_W-1:0]       bank_offset,
    output logic                    miss
);
    logic [NUM_BANKS-1:0]              match;
    logic [NUM_BANKS-1:0][WORD_W-1:0]  rel;
    logic [NUM_BANKS-1:0][21:0]        unused_bits;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_win
        bank_word_t  w;
        logic [32:0] base, diff;
        assign w     = bank_word_t'(bank_q[b]);
        assign base  = {1'b0, w.base_hi, 23'b0};
        assign diff  = {1'b0, phys_addr} - base;
        assign match[b] = ctrl_en && w.enable
                       && ({1'b0, phys_addr} >= base)
                       && (diff < window_span(w.size_code));
        assign rel[b] = diff[WORD_W-1:0];
        assign unused_bits[b] = {w.pad_a, w.pad_b, diff[32], 2'b0};
    end

    always_comb begin
        hit_valid   = 1'b0;
        hit_bank    = '0;
        bank_offset = '0;
        for (int b = NUM_BANKS - 1; b >= 0; b--) begin
            if (match[b]) begin
                hit_valid   = 1'b1;
                hit_bank    = BANK_W'(b);
                bank_offset = rel[b];
            end
        end
        miss = !hit_valid;
    end

endmodule

// File: rtl/sdram_cfg_front.sv
module sdram_cfg_front
    import sdcfg_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BUS_AW    = 10,
    parameter logic [BUS_AW-1:0] IDX_PORT  = 10'h010,
    parameter logic [BUS_AW-1:0] DATA_PORT = 10'h011,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       phys_addr,
    output logic              hit_valid,
    output logic [BANK_W-1:0] hit_bank,
    output logic [31:0]       bank_offset,
    output logic              miss,
    output logic              ecc_irq
);
    logic [NUM_BANKS-1:0][WORD_W-1:0] bank_words;
    logic              ctrl_en;
    logic [WORD_W-1:0] status_word;
    logic [WORD_W-1:0] eccerr_word;

    sdcfg_regfile #(
        .NUM_BANKS (NUM_BANKS),
        .BUS_AW    (BUS_AW),
        .IDX_PORT  (IDX_PORT),
        .DATA_PORT (DATA_PORT)
    ) i_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bank_q    (bank_words),
        .ctrl_en   (ctrl_en),
        .status_q  (status_word),
        .eccerr_q  (eccerr_word)
    );

    sdcfg_bank_decode #(
        .NUM_BANKS (NUM_BANKS)
    ) i_dec (
        .bank_q      (bank_words),
        .ctrl_en     (ctrl_en),
        .phys_addr   (phys_addr),
        .hit_valid   (hit_valid),
        .hit_bank    (hit_bank),
        .bank_offset (bank_offset),
        .miss        (miss)
    );

    assign ecc_irq = |eccerr_word;

endmodule

// File: rtl/sdcfg_checker.sv
module sdcfg_checker
    import sdcfg_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BUS_AW    = 10,
    parameter logic [BUS_AW-1:0] IDX_PORT  = 10'h010,
    parameter logic [BUS_AW-1:0] DATA_PORT = 10'h011
) (
    input logic              clk,
    input logic              rst,
    input logic [BUS_AW-1:0] bus_addr,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              hit_valid,
    input logic              miss,
    input logic              ecc_irq,
    input logic              ctrl_en,
    input logic [31:0]       status_word
);
    logic [31:0] idx_shadow;
    always_ff @(posedge clk) begin
        if (rst) idx_shadow <= '0;
        else if (bus_wr && bus_addr == IDX_PORT) idx_shadow <= bus_wdata;
    end

    wire data_wr = bus_wr && (bus_addr == DATA_PORT);

    // R11: nonzero write to the ECC error register raises the interrupt next cycle
    a_r11_irq_rise: assert property (@(posedge clk) disable iff (rst)
        (data_wr && idx_shadow == OFS_ECCERR && bus_wdata != 0) |=> ecc_irq);

    // R11: zero write drops it
    a_r11_irq_fall: assert property (@(posedge clk) disable iff (rst)
        (data_wr && idx_shadow == OFS_ECCERR && bus_wdata == 0) |=> !ecc_irq);

    // R5: with the controller off, nothing hits
    a_r5_off_misses: assert property (@(posedge clk) disable iff (rst)
        !ctrl_en |-> (miss && !hit_valid));

    // R7: controller disable edge sets status bit 31
    a_r7_disable_flag: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl_en) |-> status_word[CFG_EN_BIT]);

    // R7: controller enable edge clears status bit 31
    a_r7_enable_flag: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_en) |-> !status_word[CFG_EN_BIT]);

    // R8: writes aimed at the status offset leave it unchanged
    a_r8_status_ro: assert property (@(posedge clk) disable iff (rst)
        (data_wr && idx_shadow == OFS_STATUS) |=> $stable(status_word));

    // R3: a bank word read back never shows bits outside the mask
    a_r3_bank_mask: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == DATA_PORT && idx_shadow >= OFS_BANK0
         && idx_shadow < OFS_BANK0 + 32'(4 * NUM_BANKS) && idx_shadow[1:0] == 2'b00)
        |-> ((bus_rdata & ~MSK_BANK) == 32'h0));

endmodule

bind sdram_cfg_front sdcfg_checker #(
    .NUM_BANKS (NUM_BANKS),
    .BUS_AW    (BUS_AW),
    .IDX_PORT  (IDX_PORT),
    .DATA_PORT (DATA_PORT)
) i_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .hit_valid   (hit_valid),
    .miss        (miss),
    .ecc_irq     (ecc_irq),
    .ctrl_en     (ctrl_en),
    .status_word (status_word)
);

// File: tb/test_sdram_cfg_front.sv
module test_sdram_cfg_front;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [9:0] IDXP = 10'h010;
    localparam logic [9:0] DATP = 10'h011;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] phys_addr = '0;
    logic        hit_valid;
    logic [1:0]  hit_bank;
    logic [31:0] bank_offset;
    logic        miss;
    logic        ecc_irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_cfg_front i_sdram_cfg_front (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .phys_addr(phys_addr),
        .hit_valid(hit_valid), .hit_bank(hit_bank), .bank_offset(bank_offset),
        .miss(miss), .ecc_irq(ecc_irq)
    );

    // {offset, write value, expected readback}
    localparam int NV = 14;
    localparam logic [95:0] VEC [NV] = '{
        {32'h40, 32'hFFFF_FFFF, 32'hFFDE_E001},   // R3
        {32'h4C, 32'h1234_5679, 32'h1214_4001},   // R3
        {32'h30, 32'hFFFF_FFFF, 32'h3FF8_0000},   // R10
        {32'h80, 32'hFFFF_FFFF, 32'h018F_C01F},   // R10
        {32'h94, 32'hFFFF_FFFF, 32'h00F0_0000},   // R10
        {32'h34, 32'h0000_0000, 32'h07C0_0000},   // R10
        {32'h34, 32'hFFFF_FFFF, 32'hFFC0_0000},   // R10
        {32'h10, 32'h1234_5678, 32'h1234_5678},   // R9
        {32'h00, 32'hFFFF_FFFF, 32'h0000_0000},   // R9
        {32'h08, 32'hA5A5_A5A5, 32'h0000_0000},   // R9
        {32'h24, 32'hFFFF_FFFF, 32'h0000_0000},   // R8
        {32'h50, 32'hDEAD_BEEF, 32'h0000_0000},   // R2
        {32'h98, 32'h0000_0005, 32'h0000_0005},   // R11
        {32'h98, 32'h0000_0000, 32'h0000_0000}    // R11
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic reg_write(input logic [31:0] ofs, input logic [31:0] d);
        bus_write(IDXP, ofs);
        bus_write(DATP, d);
    endtask

    task automatic reg_read(input logic [31:0] ofs, output logic [31:0] d);
        bus_write(IDXP, ofs);
        bus_addr = DATP;
        #1 d = bus_rdata;
    endtask

    task automatic expect_reg(input string req, input logic [31:0] ofs, input logic [31:0] exp);
        logic [31:0] v;
        reg_read(ofs, v);
        check(req, v, exp);
    endtask

    task automatic probe(input string req, input logic [31:0] a, input logic v,
                         input logic [1:0] bank, input logic [31:0] ofs);
        phys_addr = a;
        #1;
        check(req, {31'b0, hit_valid}, {31'b0, v});
        check(req, {31'b0, miss}, {31'b0, !v});
        if (v) begin
            check(req, {30'b0, hit_bank}, {30'b0, bank});
            check(req, bank_offset, ofs);
        end else begin
            check(req, bank_offset, 32'h0);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        expect_reg("R1", 32'h20, 32'h0080_0000);
        expect_reg("R1", 32'h34, 32'h07C0_0000);
        expect_reg("R1", 32'h30, 32'h05F0_0000);
        expect_reg("R1", 32'h80, 32'h0085_4009);
        expect_reg("R1", 32'h24, 32'h0);
        expect_reg("R1", 32'h98, 32'h0);
        expect_reg("R1", 32'h44, 32'h0);
        check("R1", {31'b0, ecc_irq}, 32'h0);
        probe("R1", 32'h0000_1000, 1'b0, 2'd0, 32'h0);

        // R2 index register readback
        bus_write(IDXP, 32'h0000_0024);
        bus_addr = IDXP;
        #1 check("R2", bus_rdata, 32'h0000_0024);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            reg_write(VEC[i][95:64], VEC[i][63:32]);
            expect_reg("R2/R3/R8/R9/R10/R11 table", VEC[i][95:64], VEC[i][31:0]);
        end

        // R11 interrupt pin timing
        reg_write(32'h98, 32'h0000_0100);
        check("R11", {31'b0, ecc_irq}, 32'h1);
        reg_write(32'h98, 32'h0);
        check("R11", {31'b0, ecc_irq}, 32'h0);

        // R7/R8 status edges
        reg_write(32'h20, 32'h8000_0000);
        expect_reg("R7", 32'h24, 32'h0000_0000);
        reg_write(32'h20, 32'h0000_0000);
        expect_reg("R7", 32'h24, 32'h8000_0000);
        reg_write(32'h20, 32'h4000_0000);
        expect_reg("R8", 32'h24, 32'hC000_0000);
        reg_write(32'h24, 32'h0);
        expect_reg("R8", 32'h24, 32'hC000_0000);
        reg_write(32'h20, 32'hC000_0000);
        expect_reg("R7", 32'h24, 32'h4000_0000);
        reg_write(32'h20, 32'h8000_0000);
        expect_reg("R8", 32'h24, 32'h0000_0000);

        // Bank layout, controller now enabled
        reg_write(32'h40, 32'h0004_0001);   // base 0, 16 MiB
        reg_write(32'h44, 32'h0080_0001);   // base 8 MiB, 4 MiB
        reg_write(32'h48, 32'h100C_0001);   // base 256 MiB, 256 MiB
        reg_write(32'h4C, 32'h4000_0000);   // disabled
        probe("R4", 32'h0000_0040, 1'b1, 2'd0, 32'h0000_0040);
        probe("R6", 32'h0090_0000, 1'b1, 2'd0, 32'h0090_0000);
        probe("R4", 32'h1FFF_FFFC, 1'b1, 2'd2, 32'h0FFF_FFFC);
        probe("R4", 32'h1000_0000, 1'b1, 2'd2, 32'h0);
        probe("R5", 32'h2000_0000, 1'b0, 2'd0, 32'h0);
        probe("R5", 32'h4000_0010, 1'b0, 2'd0, 32'h0);
        probe("R5", 32'h0100_0000, 1'b0, 2'd0, 32'h0);

        reg_write(32'h40, 32'h0);
        probe("R6", 32'h0090_0000, 1'b1, 2'd1, 32'h0010_0000);
        probe("R4", 32'h00C0_0000, 1'b0, 2'd0, 32'h0);

        reg_write(32'h20, 32'h0);
        probe("R5", 32'h1FFF_FFFC, 1'b0, 2'd0, 32'h0);
        reg_write(32'h20, 32'h8000_0000);
        probe("R5", 32'h1FFF_FFFC, 1'b1, 2'd2, 32'h0FFF_FFFC);

        // R2 unknown offset write leaves decode and registers alone
        reg_write(32'h46, 32'hFFFF_FFFF);
        expect_reg("R2", 32'h44, 32'h0080_0001);
        probe("R2", 32'h0090_0000, 1'b1, 2'd1, 32'h0010_0000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule